// File: doc/BRIEF.md
# Serial NOR Flash Emulator

This block lets a chip answer as a small serial NOR flash on a four-wire SPI link in mode 0. The link is sampled by the system clock. Each transaction starts when chip-select goes low. The first byte is an opcode. Some opcodes are followed by an address phase, and then by data bytes sent to or returned from a byte array held inside the block. The size of that array is a parameter. Data bits are taken on the rising edge of SCLK, and MISO changes after the falling edge.

The block keeps two status bits: write-in-progress and a write-enable latch. A byte-per-clock erase engine sets array regions to 0xFF. A short countdown stands in for the program time. Programming can only turn bits from 1 to 0. A program address that runs past the end of its page goes back to the start of the same page. The address phase is three or four bytes long, and opcodes switch between the two.

Top module: `spi_nor_emu`

## Requirements
- R1: Opcode 0x9F returns the bytes 0x55, 0xAA and 0x55, in that order. Every later byte of the same transaction is 0x00.
- R2: Opcode 0x05 returns a status byte with write-in-progress in bit 0 and the write-enable latch in bit 1. All other bits are 0. Opcode 0x06 sets the latch and opcode 0x04 clears it. Both are 0 after reset.
- R3: Page program (0x02) and the erases (0x20, 0x52, 0xD8, 0x60) leave the array and the status unchanged when the write-enable latch is clear.
- R4: The address is sent MSB first. It is 3 bytes long after reset or after opcode 0xE9, and 4 bytes long after opcode 0xB7.
- R5: Each program data byte is ANDed into the stored byte.
- R6: During page program only the address bits below log2(PAGE_BYTES) advance. The address wraps inside the page and the upper bits stay fixed.
- R7: Opcodes 0x20, 0x52 and 0xD8 fill with 0xFF the region of SEC_BYTES, BLK32_BYTES or BLK64_BYTES that is aligned on its own size and holds the address. A region that is larger than the array covers the whole array. Opcode 0x60 fills the whole array. The array reads 0xFF after reset.
- R8: Read (0x03) returns successive bytes for as long as chip-select stays low. Addresses are taken modulo MEM_BYTES, so a read continues past the last byte into byte 0.
- R9: A program sets write-in-progress and clears the latch when chip-select rises. An erase does the same once its address is complete, and chip erase does it on its opcode. Write-in-progress clears PROG_CYC clocks after a program, or when the erase engine has written its last byte.
- R10: While write-in-progress is set, every opcode except 0x05 is ignored, and MISO stays 0 for that transaction.
- R11: An unknown opcode, or a transaction that ends before its address is complete, changes neither the array nor the status.
- R12: MISO is 0 while chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SPI serial clock, mode 0 |
| csn_i | input | 1 | Active-low chip-select |
| mosi_i | input | 1 | Serial data into the block |
| miso_o | output | 1 | Serial data out of the block |

## Verification
The assertions assume the following about the inputs:
- SCLK is slow compared with the system clock, with at least five system clocks in each half period.
- SCLK is low whenever chip-select changes.
- A chip-select rise never lands in the same clock as an SCLK rise.

Under these conditions a received byte and a chip-select end are never seen together, and a program write never meets an active erase. The bench drives every bit with six-clock half periods. It leaves settling gaps around each chip-select edge. It samples MISO just before each rising SCLK edge, which the timing above allows.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;
  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_BE32 = 8'h52;
  localparam logic [7:0] OP_BE64 = 8'hD8;
  localparam logic [7:0] OP_CE   = 8'h60;
  localparam logic [7:0] OP_EN4  = 8'hB7;
  localparam logic [7:0] OP_EX4  = 8'hE9;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_RD, PH_PRG, PH_ID, PH_SR, PH_SKIP
  } phase_e;

  typedef enum logic [1:0] {K_READ, K_PROG, K_ERASE} kind_e;
endpackage

// File: rtl/spi_nor_front.sv
module spi_nor_front (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       csn_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte_i,
  output logic       miso_o,
  output logic       rx_vld_o,
  output logic [7:0] rx_byte_o,
  output logic       cs_end_o
);
  logic [2:0] sclk_s, csn_s;
  logic [1:0] mosi_s;
  logic [2:0] bit_cnt_q;
  logic [6:0] rx_sh_q, tx_sh_q;
  logic       miso_q, sel, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_s <= '0;
      csn_s  <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk_i};
      csn_s  <= {csn_s[1:0], csn_i};
      mosi_s <= {mosi_s[0], mosi_i};
    end
  end

  assign sel      = !csn_s[1];
  assign rise     = sclk_s[1] & ~sclk_s[2];
  assign fall     = ~sclk_s[1] & sclk_s[2];
  assign cs_end_o = csn_s[1] & ~csn_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      miso_q    <= 1'b0;
      rx_vld_o  <= 1'b0;
      rx_byte_o <= '0;
    end else begin
      rx_vld_o <= 1'b0;
      if (!sel) begin
        bit_cnt_q <= '0;
        miso_q    <= 1'b0;
      end else begin
        if (rise) begin
          rx_sh_q   <= {rx_sh_q[5:0], mosi_s[1]};
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) begin
            rx_vld_o  <= 1'b1;
            rx_byte_o <= {rx_sh_q, mosi_s[1]};
          end
        end
        if (fall) begin
          // byte boundary: load next byte from the controller
          if (bit_cnt_q == 3'd0) begin
            miso_q  <= tx_byte_i[7];
            tx_sh_q <= tx_byte_i[6:0];
          end else begin
            miso_q  <= tx_sh_q[6];
            tx_sh_q <= {tx_sh_q[5:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso_o = miso_q;

  // R12
  miso_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_s[1] && $past(csn_s[1])) |-> !miso_o);
endmodule

// File: rtl/spi_nor_mem.sv
module spi_nor_mem #(
  parameter int MEM_BYTES = 2048,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int LW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  input  logic          pwr_en_i,
  input  logic [AW-1:0] pwr_addr_i,
  input  logic [7:0]    pwr_data_i,
  input  logic          er_start_i,
  input  logic [AW-1:0] er_base_i,
  input  logic [LW-1:0] er_len_i,
  output logic          er_busy_o,
  output logic          er_done_o
);
  logic [7:0]    mem_q [MEM_BYTES];
  logic [AW-1:0] ptr_q;
  logic [LW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
      ptr_q     <= '0;
      left_q    <= '0;
      er_busy_o <= 1'b0;
      er_done_o <= 1'b0;
    end else begin
      er_done_o <= 1'b0;
      if (er_start_i) begin
        er_busy_o <= 1'b1;
        ptr_q     <= er_base_i;
        left_q    <= er_len_i;
      end else if (er_busy_o) begin
        mem_q[ptr_q] <= 8'hFF;
        ptr_q        <= ptr_q + 1'b1;
        left_q       <= left_q - 1'b1;
        if (left_q == LW'(1)) begin
          er_busy_o <= 1'b0;
          er_done_o <= 1'b1;
        end
      end
      // program can only clear bits
      if (pwr_en_i) mem_q[pwr_addr_i] <= mem_q[pwr_addr_i] & pwr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R10
  no_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_i || er_start_i) |-> !er_busy_o);
endmodule

// File: rtl/spi_nor_ctrl.sv
module spi_nor_ctrl
  import spi_nor_pkg::*;
#(
  parameter int MEM_BYTES   = 2048,
  parameter int PAGE_BYTES  = 256,
  parameter int SEC_BYTES   = 4096,
  parameter int BLK32_BYTES = 32768,
  parameter int BLK64_BYTES = 65536,
  parameter int PROG_CYC    = 64,
  localparam int AW  = $clog2(MEM_BYTES),
  localparam int LW  = AW + 1,
  localparam int PW  = $clog2(PAGE_BYTES),
  localparam int PCW = $clog2(PROG_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_vld_i,
  input  logic [7:0]    rx_byte_i,
  input  logic          cs_end_i,
  output logic [7:0]    tx_byte_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          pwr_en_o,
  output logic [AW-1:0] pwr_addr_o,
  output logic [7:0]    pwr_data_o,
  output logic          er_start_o,
  output logic [AW-1:0] er_base_o,
  output logic [LW-1:0] er_len_o,
  input  logic          er_busy_i,
  input  logic          er_done_i
);
  localparam int SEC_LEN = (SEC_BYTES   < MEM_BYTES) ? SEC_BYTES   : MEM_BYTES;
  localparam int B32_LEN = (BLK32_BYTES < MEM_BYTES) ? BLK32_BYTES : MEM_BYTES;
  localparam int B64_LEN = (BLK64_BYTES < MEM_BYTES) ? BLK64_BYTES : MEM_BYTES;

  phase_e         phase_q;
  kind_e          kind_q;
  logic [31:0]    addr_q, addr_nx;
  logic [1:0]     acnt_q, alast, id_idx_q;
  logic           four_b_q, wel_q, wip_q;
  logic [LW-1:0]  er_len_q;
  logic [PCW-1:0] pcnt_q;
  logic           ce_go, ea_go, addr_done;

  assign addr_nx   = {addr_q[23:0], rx_byte_i};
  assign alast     = four_b_q ? 2'd3 : 2'd2;
  assign addr_done = rx_vld_i && phase_q == PH_ADDR && acnt_q == alast;
  assign ce_go = rx_vld_i && !cs_end_i && phase_q == PH_OPC && !wip_q && wel_q
                 && rx_byte_i == OP_CE;
  assign ea_go = addr_done && !cs_end_i && kind_q == K_ERASE;

  assign er_start_o = ce_go || ea_go;
  assign er_len_o   = ce_go ? LW'(MEM_BYTES) : er_len_q;
  assign er_base_o  = ce_go ? '0 : (addr_nx[AW-1:0] & ~(er_len_q[AW-1:0] - 1'b1));

  assign rd_addr_o  = addr_q[AW-1:0];
  assign pwr_en_o   = rx_vld_i && !cs_end_i && phase_q == PH_PRG;
  assign pwr_addr_o = addr_q[AW-1:0];
  assign pwr_data_o = rx_byte_i;

  always_comb begin
    unique case (phase_q)
      PH_RD:   tx_byte_o = rd_data_i;
      PH_SR:   tx_byte_o = {6'b0, wel_q, wip_q};
      PH_ID: begin
        unique case (id_idx_q)
          2'd0:    tx_byte_o = 8'h55;
          2'd1:    tx_byte_o = 8'hAA;
          2'd2:    tx_byte_o = 8'h55;
          default: tx_byte_o = 8'h00;
        endcase
      end
      default: tx_byte_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_OPC;
      kind_q   <= K_READ;
      addr_q   <= '0;
      acnt_q   <= '0;
      id_idx_q <= '0;
      four_b_q <= 1'b0;
      wel_q    <= 1'b0;
      wip_q    <= 1'b0;
      er_len_q <= '0;
      pcnt_q   <= '0;
    end else begin
      if (er_done_i) wip_q <= 1'b0;
      if (pcnt_q != '0) begin
        pcnt_q <= pcnt_q - 1'b1;
        if (pcnt_q == PCW'(1)) wip_q <= 1'b0;
      end
      if (cs_end_i) begin
        if (phase_q == PH_PRG) begin
          wip_q  <= 1'b1;
          wel_q  <= 1'b0;
          pcnt_q <= PCW'(PROG_CYC);
        end
        phase_q <= PH_OPC;
      end else if (rx_vld_i) begin
        unique case (phase_q)
          PH_OPC: begin
            acnt_q   <= '0;
            addr_q   <= '0;
            id_idx_q <= '0;
            phase_q  <= PH_SKIP;
            if (!wip_q || rx_byte_i == OP_RDSR) begin
              unique case (rx_byte_i)
                OP_RDID: phase_q <= PH_ID;
                OP_RDSR: phase_q <= PH_SR;
                OP_WREN: wel_q <= 1'b1;
                OP_WRDI: wel_q <= 1'b0;
                OP_EN4:  four_b_q <= 1'b1;
                OP_EX4:  four_b_q <= 1'b0;
                OP_READ: begin phase_q <= PH_ADDR; kind_q <= K_READ; end
                OP_PROG: if (wel_q) begin phase_q <= PH_ADDR; kind_q <= K_PROG; end
                OP_SE, OP_BE32, OP_BE64: if (wel_q) begin
                  phase_q  <= PH_ADDR;
                  kind_q   <= K_ERASE;
                  er_len_q <= (rx_byte_i == OP_SE)   ? LW'(SEC_LEN) :
                              (rx_byte_i == OP_BE32) ? LW'(B32_LEN) : LW'(B64_LEN);
                end
                OP_CE: if (wel_q) begin wip_q <= 1'b1; wel_q <= 1'b0; end
                default: ;
              endcase
            end
          end
          PH_ADDR: begin
            addr_q <= addr_nx;
            acnt_q <= acnt_q + 2'd1;
            if (acnt_q == alast) begin
              unique case (kind_q)
                K_READ:  phase_q <= PH_RD;
                K_PROG:  phase_q <= PH_PRG;
                default: begin phase_q <= PH_SKIP; wip_q <= 1'b1; wel_q <= 1'b0; end
              endcase
            end
          end
          PH_RD:  addr_q <= addr_q + 32'd1;
          PH_PRG: addr_q[PW-1:0] <= addr_q[PW-1:0] + 1'b1;
          PH_ID:  if (id_idx_q != 2'd3) id_idx_q <= id_idx_q + 2'd1;
          default: ;
        endcase
      end
    end
  end

  // R9
  wel_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_q) |-> !wel_q);
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    er_busy_i |-> wip_q);
  // R3
  er_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    er_start_o |-> (wel_q && !er_busy_i));
  // R2
  wel_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_q) |-> $past(rx_vld_i && rx_byte_i == OP_WREN));
  // R6
  page_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_en_o |=> (phase_q != PH_PRG) || (addr_q[31:PW] == $past(addr_q[31:PW])));
endmodule

// File: rtl/spi_nor_emu.sv
module spi_nor_emu #(
  parameter int MEM_BYTES   = 2048,
  parameter int PAGE_BYTES  = 256,
  parameter int SEC_BYTES   = 4096,
  parameter int BLK32_BYTES = 32768,
  parameter int BLK64_BYTES = 65536,
  parameter int PROG_CYC    = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic miso_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int LW = AW + 1;

  logic          rx_vld, cs_end, pwr_en, er_start, er_busy, er_done;
  logic [7:0]    rx_byte, tx_byte, rd_data, pwr_data;
  logic [AW-1:0] rd_addr, pwr_addr, er_base;
  logic [LW-1:0] er_len;

  spi_nor_front u_front (
    .clk_i, .rst_ni, .sclk_i, .csn_i, .mosi_i,
    .tx_byte_i(tx_byte), .miso_o,
    .rx_vld_o(rx_vld), .rx_byte_o(rx_byte), .cs_end_o(cs_end)
  );

  spi_nor_ctrl #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .SEC_BYTES(SEC_BYTES),
    .BLK32_BYTES(BLK32_BYTES), .BLK64_BYTES(BLK64_BYTES), .PROG_CYC(PROG_CYC)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .rx_vld_i(rx_vld), .rx_byte_i(rx_byte), .cs_end_i(cs_end),
    .tx_byte_o(tx_byte), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .pwr_en_o(pwr_en), .pwr_addr_o(pwr_addr), .pwr_data_o(pwr_data),
    .er_start_o(er_start), .er_base_o(er_base), .er_len_o(er_len),
    .er_busy_i(er_busy), .er_done_i(er_done)
  );

  spi_nor_mem #(.MEM_BYTES(MEM_BYTES)) u_mem (
    .clk_i, .rst_ni,
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pwr_en_i(pwr_en), .pwr_addr_i(pwr_addr), .pwr_data_i(pwr_data),
    .er_start_i(er_start), .er_base_i(er_base), .er_len_i(er_len),
    .er_busy_o(er_busy), .er_done_o(er_done)
  );
endmodule

// File: tb/spi_nor_emu_tb.sv
module spi_nor_emu_tb;
  localparam int MEM = 256, PG = 16, SEC = 32, B32 = 64, B64 = 128, PCYC = 1000;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso;
  int checks = 0, errors = 0;
  logic [7:0] m [MEM];
  logic [7:0] pb [16];
  bit fb = 1'b0;

  always #4 clk = ~clk;

  spi_nor_emu #(.MEM_BYTES(MEM), .PAGE_BYTES(PG), .SEC_BYTES(SEC),
    .BLK32_BYTES(B32), .BLK64_BYTES(B64), .PROG_CYC(PCYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi), .miso_o(miso));

  task automatic wn(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wn(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      wn(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_lo; csn = 1'b0; wn(4); endtask
  task automatic cs_hi; wn(2); csn = 1'b1; wn(6); chk("R12 idle miso", miso, 0); endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_lo; xfer(op, d); cs_hi;
  endtask

  task automatic rd_sr(output logic [7:0] s);
    logic [7:0] d;
    cs_lo; xfer(8'h05, d); xfer(8'h00, s); cs_hi;
  endtask

  task automatic sr_chk(input string tag, input logic [7:0] exp);
    logic [7:0] s;
    rd_sr(s); chk(tag, s, exp);
  endtask

  task automatic send_addr(input logic [31:0] a);
    logic [7:0] d;
    if (fb) xfer(a[31:24], d);
    xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
  endtask

  task automatic wait_idle;
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rd_sr(s);
      if (!s[0]) break;
    end
  endtask

  task automatic prog(input logic [31:0] a, input int n, input bit eff, input bit wt);
    logic [7:0] d;
    cs_lo; xfer(8'h02, d); send_addr(a);
    for (int i = 0; i < n; i++) begin
      xfer(pb[i], d);
      if (eff) begin
        int ix;
        ix = ((a & ~(PG - 1)) | ((a + i) & (PG - 1))) % MEM;
        m[ix] = m[ix] & pb[i];
      end
    end
    cs_hi;
    if (wt) wait_idle;
  endtask

  task automatic erase(input logic [7:0] op, input logic [31:0] a, input bit eff);
    logic [7:0] d;
    int len, base;
    cs_lo; xfer(op, d); send_addr(a); cs_hi;
    len  = (op == 8'h20) ? SEC : (op == 8'h52) ? B32 : B64;
    base = (a % MEM) & ~(len - 1);
    if (eff) for (int i = 0; i < len; i++) m[base + i] = 8'hFF;
    wait_idle;
  endtask

  task automatic rd_chk(input logic [31:0] a, input int n, input string tag);
    logic [7:0] d;
    cs_lo; xfer(8'h03, d); send_addr(a);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, d);
      chk(tag, d, m[(a + i) % MEM]);
    end
    cs_hi;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < MEM; i++) m[i] = 8'hFF;
    wn(5); rst_n = 1'b1; wn(5);
    chk("R12 reset miso", miso, 0);
    sr_chk("R2 reset status", 8'h00);

    // R1 identification
    cs_lo; xfer(8'h9F, d);
    xfer(8'h00, d); chk("R1 id0", d, 8'h55);
    xfer(8'h00, d); chk("R1 id1", d, 8'hAA);
    xfer(8'h00, d); chk("R1 id2", d, 8'h55);
    xfer(8'h00, d); chk("R1 id3", d, 8'h00);
    xfer(8'h00, d); chk("R1 id4", d, 8'h00);
    cs_hi;

    rd_chk(0, MEM, "R7 reset erased / R8 sweep");

    // R3 program without latch
    pb[0] = 8'h00; prog(32'h10, 1, 0, 0);
    rd_chk(32'h10, 1, "R3 program ignored");
    sr_chk("R3 status unchanged", 8'h00);

    cmd1(8'h06); sr_chk("R2 latch set", 8'h02);
    cmd1(8'h04); sr_chk("R2 latch cleared", 8'h00);

    // R6 page wrap, R9 busy, R10 lockout
    cmd1(8'h06);
    pb[0] = 8'hA5; pb[1] = 8'h3C; pb[2] = 8'h0F; pb[3] = 8'hF0;
    prog(32'h1E, 4, 1, 0);
    sr_chk("R9 after program", 8'h01);
    cmd1(8'h06);
    cs_lo; xfer(8'h03, d); send_addr(32'h1E);
    xfer(8'h00, d); chk("R10 read locked", d, 8'h00);
    xfer(8'h00, d); chk("R10 read locked", d, 8'h00);
    cs_hi;
    wait_idle;
    sr_chk("R10 wren ignored", 8'h00);
    rd_chk(32'h10, 16, "R6 page wrap");

    // R5 AND programming
    cmd1(8'h06);
    pb[0] = 8'hFF; pb[1] = 8'h81; prog(32'h10, 2, 1, 1);
    rd_chk(32'h10, 2, "R5 and");
    chk("R5 model", m[8'h11], 8'h80);

    // R8 modulo addressing and wrap
    rd_chk(32'h31E, 4, "R8 beyond array");
    rd_chk(32'hF8, 16, "R8 wrap end");

    // R4 address length
    cmd1(8'hB7); fb = 1'b1;
    cmd1(8'h06);
    pb[0] = 8'h12; pb[1] = 8'h34; prog(32'h0100_0045, 2, 1, 1);
    rd_chk(32'h0000_0045, 2, "R4 four byte");
    cmd1(8'hE9); fb = 1'b0;
    rd_chk(32'h45, 2, "R4 three byte");

    // boundary markers for erase checks
    begin
      int marks [6] = '{8'h1F, 8'h20, 8'h3F, 8'h40, 8'h7F, 8'hFF};
      foreach (marks[k]) begin
        cmd1(8'h06); pb[0] = 8'h00; prog(marks[k], 1, 1, 1);
      end
      cmd1(8'h06); pb[0] = 8'h00; prog(32'h80, 1, 1, 1);
    end

    erase(8'h20, 32'h25, 0);
    rd_chk(32'h20, 1, "R3 erase ignored");

    cmd1(8'h06); erase(8'h20, 32'h25, 1);
    sr_chk("R9 latch cleared by erase", 8'h00);
    rd_chk(32'h1E, 4, "R7 sector low edge");
    rd_chk(32'h3E, 4, "R7 sector high edge");
    cmd1(8'h06); erase(8'h52, 32'h45, 1);
    rd_chk(32'h3C, 72, "R7 block32");
    cmd1(8'h06); erase(8'hD8, 32'h85, 1);
    rd_chk(32'h7C, 8, "R7 block64 low");
    rd_chk(32'hFC, 8, "R7 block64 wrap");

    // R11 truncated address and unknown opcode
    cmd1(8'h06);
    cs_lo; xfer(8'h20, d); xfer(8'h00, d); xfer(8'h00, d); cs_hi;
    sr_chk("R11 truncated erase", 8'h02);
    cmd1(8'h04);
    cmd1(8'hAB);
    sr_chk("R11 unknown opcode", 8'h00);
    rd_chk(0, MEM, "R11 array intact");

    // chip erase
    cmd1(8'h06); cmd1(8'h60);
    sr_chk("R9 chip erase busy", 8'h01);
    wait_idle;
    sr_chk("R9 chip erase done", 8'h00);
    for (int i = 0; i < MEM; i++) m[i] = 8'hFF;
    rd_chk(0, MEM, "R7 chip erase");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule